// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This unit performs 32x32 multiplication and 32/32 division, signed or unsigned, one bit per clock. A single-cycle start pulse carries a two-bit opcode and two operands. The unit then works for a fixed number of cycles and writes its result into an internal register pair. The pair is called HI and LO and is always visible on two read ports, so a processor can serve move-from-HI and move-from-LO instructions directly.

Multiplication uses shift-and-add: each cycle adds the multiplicand into the upper half of a running product when the current multiplier bit is set, then shifts. Division uses restoring long division: each cycle trial-subtracts the divisor from the partial remainder and keeps or restores it. Signed variants work on magnitudes and fix the signs at the end. A zero divisor is not trapped. It yields a defined result in the normal time.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy is 0 and both hi and lo read 0.
- R2: A clock edge with start high and busy low accepts an operation. The opcode values are: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide. busy is high from the next cycle.
- R3: busy stays high for exactly 32 cycles after the accepting edge. hi and lo change together only at the edge where busy falls and hold their values at all other times.
- R4: Unsigned multiply places bits 63:32 of the 64-bit product of the operands on hi and bits 31:0 on lo.
- R5: Signed multiply places the 64-bit two's-complement product on hi:lo. This includes operands equal to the most negative value.
- R6: Unsigned divide places the quotient on lo and the remainder on hi.
- R7: Signed divide truncates the quotient toward zero. The remainder has the sign of the dividend. Dividing the most negative value by -1 gives lo = 32'h80000000 and hi = 0.
- R8: A divide with a zero divisor, signed or unsigned, finishes in the normal 32 cycles with lo = 32'hFFFFFFFF and hi equal to the dividend.
- R9: A start pulse while busy is high is ignored. Its opcode and operands change neither the result nor the timing of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation |
| op | input | 2 | Operation code (see R2) |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
A bad iteration counter shows on busy within one operation, as a drop that comes too early or too late. A corrupted partial product or partial remainder stays hidden until busy falls and then shows as a wrong hi or lo on that same edge. Wrong sign flags show only for mixed-sign or most-negative operands, so those cases are applied on purpose. The bench compares busy, hi and lo with a behavioural model on every clock, so any difference is caught within the cycle in which it appears.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W) + 1;

  logic [CW-1:0] cnt;
  logic          is_div, neg_q, neg_r;
  logic [W-1:0]  acc, sh_reg, arg;
  logic [W-1:0]  hi_r, lo_r;

  wire        sgn    = ~op[0];
  wire        a_neg  = sgn & opa[W-1];
  wire        b_neg  = sgn & opb[W-1];
  wire [W-1:0] a_mag = a_neg ? -opa : opa;
  wire [W-1:0] b_mag = b_neg ? -opb : opb;
  wire        accept = start & ~busy;
  wire        last   = busy & (cnt == CW'(1));

  wire [W:0]   m_sum = {1'b0, acc} + (sh_reg[0] ? {1'b0, arg} : {(W+1){1'b0}});
  wire [W-1:0] m_acc = m_sum[W:1];
  wire [W-1:0] m_low = {m_sum[0], sh_reg[W-1:1]};

  wire [W:0]   d_sh   = {acc, sh_reg[W-1]};
  wire [W+1:0] d_diff = {1'b0, d_sh} - {2'b00, arg};
  wire         d_neg  = d_diff[W+1];
  wire [W-1:0] d_acc  = d_neg ? d_sh[W-1:0] : d_diff[W-1:0];
  wire [W-1:0] d_low  = {sh_reg[W-2:0], ~d_neg};

  wire [W-1:0]   n_acc = is_div ? d_acc : m_acc;
  wire [W-1:0]   n_low = is_div ? d_low : m_low;
  wire [2*W-1:0] prod  = {m_acc, m_low};
  wire [2*W-1:0] prod_s = neg_q ? -prod : prod;
  wire [W-1:0]   rem_s = neg_r ? -d_acc : d_acc;
  wire [W-1:0]   quo_s = neg_q ? -d_low : d_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      is_div <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      acc    <= '0;
      sh_reg <= '0;
      arg    <= '0;
      hi_r   <= '0;
      lo_r   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= CW'(W);
      is_div <= op[1];
      neg_q  <= (a_neg ^ b_neg) & ~(op[1] & (opb == '0));
      neg_r  <= a_neg;
      acc    <= '0;
      sh_reg <= op[1] ? a_mag : b_mag;
      arg    <= op[1] ? b_mag : a_mag;
    end else if (busy) begin
      acc    <= n_acc;
      sh_reg <= n_low;
      cnt    <= cnt - CW'(1);
      if (last) begin
        busy <= 1'b0;
        if (is_div) begin
          hi_r <= rem_s;
          lo_r <= quo_s;
        end else begin
          hi_r <= prod_s[2*W-1:W];
          lo_r <= prod_s[W-1:0];
        end
      end
    end
  end

  assign hi = hi_r;
  assign lo = lo_r;
endmodule

module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic [$clog2(W)+1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run == W - 1) |=> !busy);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run < W - 1) |=> busy);
  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(hi) && $stable(lo)));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .hi(hi), .lo(lo));

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy;
  logic [31:0] hi, lo;

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  muldiv_hilo u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opa(opa), .opb(opb), .busy(busy), .hi(hi), .lo(lo));

  bit          m_busy = 0;
  int          m_cnt = 0;
  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  string       tag = "R1", p_tag = "R1";

  function automatic void model(input logic [1:0] c, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] rh,
                                output logic [31:0] rl, output string t);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    logic [63:0] p;
    case (c)
      2'b00: begin p = 64'(sa * sb); t = "R5"; end
      2'b01: begin p = 64'(a) * 64'(b); t = "R4"; end
      2'b10: begin
        t = "R7";
        if (b == 0) p = {a, 32'hFFFFFFFF};
        else p = {32'(sa % sb), 32'(sa / sb)};
      end
      default: begin
        t = "R6";
        if (b == 0) p = {a, 32'hFFFFFFFF};
        else p = {a % b, a / b};
      end
    endcase
    if (c[1] && b == 0) t = "R8";
    rh = p[63:32];
    rl = p[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_hi = '0; m_lo = '0; tag = "R1";
    end else if (m_busy) begin
      if (start) p_tag = "R9";
      if (m_cnt == 1) begin
        m_busy = 0; m_hi = p_hi; m_lo = p_lo; tag = p_tag;
      end else m_cnt--;
    end else if (start) begin
      model(op, opa, opb, p_hi, p_lo, p_tag);
      m_busy = 1; m_cnt = 32; tag = "R3";
    end
  end

  always @(negedge clk) begin
    cycles++;
    n_cmp++;
    if (busy !== m_busy) begin
      n_bad++;
      $display("FAIL R3 busy: actual %0b expected %0b", busy, m_busy);
    end else if (hi !== m_hi || lo !== m_lo) begin
      n_bad++;
      $display("FAIL %s hi/lo: actual %h_%h expected %h_%h", tag, hi, lo, m_hi, m_lo);
    end
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; op = c; opa = a; opb = b;
    @(negedge clk);
    start = 0;
    repeat (34) @(negedge clk);
  endtask

  task automatic run_poke(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; op = c; opa = a; opb = b;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1; op = ~c; opa = 32'h1234_5678; opb = 32'h0000_0003;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(2'b01, 32'd12, 32'd11);
    run(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run(2'b01, 32'h0, 32'hDEADBEEF);
    run(2'b00, 32'hFFFFFFF9, 32'd6);
    run(2'b00, 32'h80000000, 32'h80000000);
    run(2'b00, 32'h80000000, 32'hFFFFFFFF);
    run(2'b00, 32'h7FFFFFFF, 32'h80000000);
    run(2'b11, 32'd100, 32'd7);
    run(2'b11, 32'hFFFFFFFF, 32'd1);
    run(2'b11, 32'd5, 32'hFFFFFFF0);
    run(2'b10, 32'hFFFFFFF9, 32'd2);
    run(2'b10, 32'd7, 32'hFFFFFFFE);
    run(2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE);
    run(2'b10, 32'h80000000, 32'hFFFFFFFF);
    run(2'b10, 32'hFFFFFF85, 32'd0);
    run(2'b11, 32'hCAFEF00D, 32'd0);
    run_poke(2'b01, 32'd1000, 32'd3000);
    run_poke(2'b10, 32'hFFFF0000, 32'd7);
    @(negedge clk);
    start = 1; op = 2'b11; opa = 32'd999; opb = 32'd10;
    repeat (70) @(negedge clk);
    start = 0;
    repeat (34) @(negedge clk);
    for (int i = 0; i < 60; i++)
      run(2'($urandom), $urandom, (i % 7 == 0) ? 32'($urandom % 5) : $urandom);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule